// File: doc/BRIEF.md
# Prioritised Ownership Arbiter for a Shared Coprocessor

This block decides which of five requesters, numbered 0 to 4, owns a shared security coprocessor at any moment. Each requester writes a one-byte control word through a write strobe tagged with its number. It reads back one of three status views, selected by a view code and tagged with its own number.

Ownership is normally taken by asking for it. When the coprocessor is free, the highest-numbered waiting requester receives it. The owner gives it back by releasing it. A higher-numbered requester may also take ownership by force. The owner that loses it this way keeps a sticky flag until it asks again.

A platform-established flag can be set only by requesters 3 and 4. The active owner, the grant vector, the forced-loss vector and the "someone else is waiting" vector are also driven as plain output ports.

Top module: `loc_access_arbiter`

## Requirements
- R1: In reset, and out of reset until the first clock edge, no owner is assigned, all per-requester vectors are 0, the established flag is 0 and the valid bit (bit 7 of every view) reads 0. From the first edge after reset on, the valid bit reads 1.
- R2: A control write with bit 1 (ask) from a requester that does not own the coprocessor marks that requester as waiting. If the coprocessor is free, it is granted on the following edge, so it is visible two edges after the write edge.
- R3: When the coprocessor is free and several requesters are waiting, the highest-numbered one is granted on the first edge after the release, and its waiting mark clears.
- R4: A control write with bit 2 (release) from the current owner frees the coprocessor. The same write from any other requester changes nothing.
- R5: A control write with bit 3 (take) from a requester numbered above the current owner, or issued while no one owns the coprocessor, makes the writer the owner on the next edge. A displaced owner gets its forced-loss flag set.
- R6: A take from a requester numbered at or below the current owner is ignored.
- R7: A forced-loss flag stays set until that same requester issues an ask.
- R8: `others_wait_o[n]` is 1 when any requester other than n is waiting.
- R9: A control write with bit 0 sets the established flag only when it comes from requester 3 or 4. From requesters 0 to 2 it is ignored.
- R10: View code 1 reads valid in bit 7, the owner number in bits 4:2, "owner assigned" in bit 1 and the established flag in bit 0.
- R11: View code 0 for requester n reads valid in bit 7, "n is owner" in bit 5, n's forced-loss flag in bit 4, others-waiting in bit 2, n's own waiting mark in bit 1 and the established flag in bit 0.
- R12: View code 2 reads n's forced-loss flag in bit 1 and "n is owner" in bit 0. View code 3 reads 0.
- R13: Writes tagged with a requester number above 4 are ignored. When one write carries several of bits 1 to 3, take wins over release, and release wins over ask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control write strobe |
| wr_loc_i | input | 3 | Requester number of the write |
| wr_data_i | input | 8 | Control byte: bit 0 establish, 1 ask, 2 release, 3 take |
| rd_loc_i | input | 3 | Requester number of the read view |
| rd_sel_i | input | 2 | View code: 0 access, 1 state, 2 status, 3 none |
| rd_data_o | output | 8 | Selected view, combinational |
| owner_o | output | 3 | Current owner number |
| assigned_o | output | 1 | An owner is assigned |
| granted_o | output | 5 | One-hot owner vector |
| seized_o | output | 5 | Forced-loss flags |
| others_wait_o | output | 5 | Per requester: another requester is waiting |
| established_o | output | 1 | Platform-established flag |

## Verification
A corrupted owner register shows up on `granted_o`, `owner_o` and the state view in the same cycle it is wrong. A lost or spurious waiting mark shows up as a missing or unexpected grant one edge after the next release, and on `others_wait_o` at once. Forced-loss and established flags are checked right after the write that should, or should not, have changed them. The ignore rules are proven by reading the unchanged owner and flags before any later write.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam int unsigned CTL_EST   = 0;
  localparam int unsigned CTL_ASK   = 1;
  localparam int unsigned CTL_REL   = 2;
  localparam int unsigned CTL_TAKE  = 3;

  typedef enum logic [1:0] {
    VIEW_ACCESS = 2'd0,
    VIEW_STATE  = 2'd1,
    VIEW_STATUS = 2'd2,
    VIEW_NONE   = 2'd3
  } view_e;
endpackage

// File: rtl/loc_prio_pick.sv
module loc_prio_pick #(
  parameter int unsigned N   = 5,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  // later (higher) index overrides earlier
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/loc_owner_ctl.sv
module loc_owner_ctl
  import loc_arb_pkg::*;
#(
  parameter int unsigned N           = 5,
  parameter int unsigned DW          = 8,
  parameter int unsigned EST_MIN_LOC = 3,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_loc_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          own_valid_o,
  output logic [IW-1:0] own_idx_o,
  output logic [N-1:0]  wait_o,
  output logic [N-1:0]  seized_o,
  output logic          est_o
);
  logic          valid_q, valid_d;
  logic [IW-1:0] owner_q, owner_d;
  logic [N-1:0]  wait_q, wait_d, seized_q, seized_d;
  logic          est_q, est_d;
  logic          pick_any;
  logic [IW-1:0] pick_idx;
  logic          loc_ok;
  logic [N-1:0]  wr_oh;

  loc_prio_pick #(.N(N)) i_pick (
    .req_i (wait_q),
    .any_o (pick_any),
    .idx_o (pick_idx)
  );

  assign loc_ok = wr_en_i && (32'(wr_loc_i) < N);

  always_comb begin
    for (int i = 0; i < N; i++) wr_oh[i] = loc_ok && (32'(wr_loc_i) == i);
  end

  always_comb begin
    valid_d  = valid_q;
    owner_d  = owner_q;
    wait_d   = wait_q;
    seized_d = seized_q;
    est_d    = est_q;
    // arbitration on registered state
    if (!valid_q && pick_any) begin
      valid_d = 1'b1;
      owner_d = pick_idx;
      for (int i = 0; i < N; i++) if (32'(pick_idx) == i) wait_d[i] = 1'b0;
    end
    // software write on top
    if (loc_ok) begin
      if (wr_data_i[CTL_TAKE]) begin
        if (!valid_d || (wr_loc_i > owner_d)) begin
          if (valid_d) begin
            for (int i = 0; i < N; i++) if (32'(owner_d) == i) seized_d[i] = 1'b1;
          end
          valid_d = 1'b1;
          owner_d = wr_loc_i;
          wait_d  = wait_d & ~wr_oh;
        end
      end else if (wr_data_i[CTL_REL]) begin
        if (valid_d && (owner_d == wr_loc_i)) valid_d = 1'b0;
      end else if (wr_data_i[CTL_ASK]) begin
        seized_d = seized_d & ~wr_oh;
        if (!(valid_d && (owner_d == wr_loc_i))) wait_d = wait_d | wr_oh;
      end
      if (wr_data_i[CTL_EST] && (32'(wr_loc_i) >= EST_MIN_LOC)) est_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      owner_q  <= '0;
      wait_q   <= '0;
      seized_q <= '0;
      est_q    <= 1'b0;
    end else begin
      valid_q  <= valid_d;
      owner_q  <= owner_d;
      wait_q   <= wait_d;
      seized_q <= seized_d;
      est_q    <= est_d;
    end
  end

  assign own_valid_o = valid_q;
  assign own_idx_o   = owner_q;
  assign wait_o      = wait_q;
  assign seized_o    = seized_q;
  assign est_o       = est_q;

  a_r3_free_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_q && |wait_q) |=> valid_q);

  a_r4_owner_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_ok && wr_data_i[CTL_REL] && !wr_data_i[CTL_TAKE] && valid_q && wr_loc_i == owner_q)
    |=> !valid_q);

  a_r5_take_over: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_ok && wr_data_i[CTL_TAKE] && valid_q && wr_loc_i > owner_q)
    |=> (valid_q && owner_q == $past(wr_loc_i) && seized_q[$past(owner_q)]));

  a_r6_low_take_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_ok && wr_data_i[CTL_TAKE] && valid_q && wr_loc_i <= owner_q)
    |=> (valid_q && owner_q == $past(owner_q)));

  a_r9_est_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(est_q) |-> $past(loc_ok && wr_data_i[CTL_EST] && 32'(wr_loc_i) >= EST_MIN_LOC));
endmodule

// File: rtl/loc_view_mux.sv
module loc_view_mux
  import loc_arb_pkg::*;
#(
  parameter int unsigned N  = 5,
  parameter int unsigned DW = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          regs_ok_i,
  input  logic [IW-1:0] rd_loc_i,
  input  logic [1:0]    rd_sel_i,
  input  logic          own_valid_i,
  input  logic [IW-1:0] own_idx_i,
  input  logic [N-1:0]  granted_i,
  input  logic [N-1:0]  wait_i,
  input  logic [N-1:0]  seized_i,
  input  logic [N-1:0]  others_wait_i,
  input  logic          est_i,
  output logic [DW-1:0] rd_data_o
);
  logic is_own, is_seized, is_wait, oth_wait;

  always_comb begin
    is_own = 1'b0; is_seized = 1'b0; is_wait = 1'b0; oth_wait = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (32'(rd_loc_i) == i) begin
        is_own    = granted_i[i];
        is_seized = seized_i[i];
        is_wait   = wait_i[i];
        oth_wait  = others_wait_i[i];
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (view_e'(rd_sel_i))
      VIEW_ACCESS: begin
        rd_data_o[7] = regs_ok_i;
        rd_data_o[5] = is_own;
        rd_data_o[4] = is_seized;
        rd_data_o[2] = oth_wait;
        rd_data_o[1] = is_wait;
        rd_data_o[0] = est_i;
      end
      VIEW_STATE: begin
        rd_data_o[7]   = regs_ok_i;
        rd_data_o[4:2] = 3'(own_idx_i);
        rd_data_o[1]   = own_valid_i;
        rd_data_o[0]   = est_i;
      end
      VIEW_STATUS: begin
        rd_data_o[1] = is_seized;
        rd_data_o[0] = is_own;
      end
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/loc_access_arbiter.sv
module loc_access_arbiter
  import loc_arb_pkg::*;
#(
  parameter int unsigned N           = 5,
  parameter int unsigned DW          = 8,
  parameter int unsigned EST_MIN_LOC = 3,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_loc_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [IW-1:0] rd_loc_i,
  input  logic [1:0]    rd_sel_i,
  output logic [DW-1:0] rd_data_o,
  output logic [IW-1:0] owner_o,
  output logic          assigned_o,
  output logic [N-1:0]  granted_o,
  output logic [N-1:0]  seized_o,
  output logic [N-1:0]  others_wait_o,
  output logic          established_o
);
  logic          own_valid;
  logic [IW-1:0] own_idx;
  logic [N-1:0]  wait_v, seized_v;
  logic          est;
  logic          regs_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) regs_ok_q <= 1'b0;
    else         regs_ok_q <= 1'b1;
  end

  loc_owner_ctl #(.N(N), .DW(DW), .EST_MIN_LOC(EST_MIN_LOC)) i_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_loc_i    (wr_loc_i),
    .wr_data_i   (wr_data_i),
    .own_valid_o (own_valid),
    .own_idx_o   (own_idx),
    .wait_o      (wait_v),
    .seized_o    (seized_v),
    .est_o       (est)
  );

  for (genvar g = 0; g < N; g++) begin : g_loc
    assign granted_o[g]     = own_valid && (32'(own_idx) == g);
    assign others_wait_o[g] = |(wait_v & ~(N'(1) << g));
  end

  loc_view_mux #(.N(N), .DW(DW)) i_view (
    .regs_ok_i     (regs_ok_q),
    .rd_loc_i      (rd_loc_i),
    .rd_sel_i      (rd_sel_i),
    .own_valid_i   (own_valid),
    .own_idx_i     (own_idx),
    .granted_i     (granted_o),
    .wait_i        (wait_v),
    .seized_i      (seized_v),
    .others_wait_i (others_wait_o),
    .est_i         (est),
    .rd_data_o     (rd_data_o)
  );

  assign owner_o       = own_idx;
  assign assigned_o    = own_valid;
  assign seized_o      = seized_v;
  assign established_o = est;

  a_r7_seized_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(seized_v) & ~seized_v)) |->
      $past(wr_en_i && wr_data_i[CTL_ASK] && !wr_data_i[CTL_TAKE] && !wr_data_i[CTL_REL]));

  a_r2_one_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(granted_o) && (assigned_o == (|granted_o)));
endmodule

// File: tb/test_loc_access_arbiter.sv
module test_loc_access_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_loc = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_loc = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic [2:0] owner;
  logic       assigned, established;
  logic [4:0] granted, seized, others_wait;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  loc_access_arbiter i_loc_access_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_loc_i(wr_loc),
    .wr_data_i(wr_data), .rd_loc_i(rd_loc), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .owner_o(owner), .assigned_o(assigned),
    .granted_o(granted), .seized_o(seized), .others_wait_o(others_wait),
    .established_o(established)
  );

  // {loc, data, exp owner, exp assigned, exp granted, exp seized, exp others_wait}
  localparam logic [29:0] VEC [12] = '{
    {3'd1, 8'h02, 3'd1, 1'b1, 5'b00010, 5'b00000, 5'b00000}, // R2 ask while free
    {3'd0, 8'h02, 3'd1, 1'b1, 5'b00010, 5'b00000, 5'b11110}, // R2 R8 ask while busy
    {3'd2, 8'h08, 3'd2, 1'b1, 5'b00100, 5'b00010, 5'b11110}, // R5 take from higher
    {3'd1, 8'h08, 3'd2, 1'b1, 5'b00100, 5'b00010, 5'b11110}, // R6 lower take ignored
    {3'd3, 8'h02, 3'd2, 1'b1, 5'b00100, 5'b00010, 5'b11111}, // R8 two waiting
    {3'd2, 8'h04, 3'd3, 1'b1, 5'b01000, 5'b00010, 5'b11110}, // R3 highest picked
    {3'd1, 8'h02, 3'd3, 1'b1, 5'b01000, 5'b00000, 5'b11111}, // R7 ask clears flag
    {3'd3, 8'h04, 3'd1, 1'b1, 5'b00010, 5'b00000, 5'b11110}, // R3 R4 release
    {3'd0, 8'h04, 3'd1, 1'b1, 5'b00010, 5'b00000, 5'b11110}, // R4 non-owner release
    {3'd4, 8'h0E, 3'd4, 1'b1, 5'b10000, 5'b00010, 5'b11110}, // R13 take wins
    {3'd5, 8'h08, 3'd4, 1'b1, 5'b10000, 5'b00010, 5'b11110}, // R13 bad number
    {3'd4, 8'h04, 3'd0, 1'b1, 5'b00001, 5'b00010, 5'b00000}  // R3 R4 last waiter
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write on one edge, idle on the next, return at the following negedge
  task automatic step(logic [2:0] loc, logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_loc = loc; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    @(negedge clk);
  endtask

  task automatic rd(logic [2:0] loc, logic [1:0] sel, string req, logic [7:0] exp);
    rd_loc = loc; rd_sel = sel;
    #1;
    chk(req, 32'(rd_data), 32'(exp));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #20;
    // R1 reset state
    chk("R1 assigned", 32'(assigned), 0);
    chk("R1 granted", 32'(granted), 0);
    chk("R1 seized", 32'(seized), 0);
    chk("R1 others_wait", 32'(others_wait), 0);
    chk("R1 established", 32'(established), 0);
    rd(3'd0, 2'd1, "R1 valid low", 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    #1 rd(3'd0, 2'd1, "R1 valid low after release", 8'h00);
    @(negedge clk);
    rd(3'd0, 2'd1, "R1 valid high", 8'h80);

    for (int v = 0; v < 12; v++) begin
      step(VEC[v][29:27], VEC[v][26:19]);
      chk($sformatf("vec%0d owner", v), 32'(owner), 32'(VEC[v][18:16]));
      chk($sformatf("vec%0d assigned", v), 32'(assigned), 32'(VEC[v][15]));
      chk($sformatf("vec%0d granted", v), 32'(granted), 32'(VEC[v][14:10]));
      chk($sformatf("vec%0d seized", v), 32'(seized), 32'(VEC[v][9:5]));
      chk($sformatf("vec%0d others_wait", v), 32'(others_wait), 32'(VEC[v][4:0]));
    end

    // views: owner 0, requester 1 seized, nobody waiting
    rd(3'd1, 2'd0, "R11 access loser", 8'h90);
    rd(3'd0, 2'd0, "R11 access owner", 8'hA0);
    rd(3'd2, 2'd1, "R10 state view", 8'h82);
    rd(3'd1, 2'd2, "R12 status loser", 8'h02);
    rd(3'd0, 2'd2, "R12 status owner", 8'h01);
    rd(3'd0, 2'd3, "R12 none view", 8'h00);

    step(3'd2, 8'h01);
    chk("R9 low establish ignored", 32'(established), 0);
    step(3'd3, 8'h01);
    chk("R9 establish from 3", 32'(established), 1);
    rd(3'd4, 2'd1, "R10 state with est", 8'h83);

    step(3'd0, 8'h04);
    chk("R4 owner release", 32'(assigned), 0);
    step(3'd2, 8'h08);
    chk("R5 take while free", 32'(granted), 32'h04);
    chk("R5 no new seized", 32'(seized), 32'h02);
    step(3'd7, 8'h02);
    chk("R13 bad number ask", 32'(others_wait), 0);
    step(3'd1, 8'h02);
    chk("R7 seized cleared", 32'(seized), 0);
    chk("R8 waiting loc1", 32'(others_wait), 32'h1D);
    rd(3'd1, 2'd0, "R11 own wait bit", 8'h83);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule